// File: doc/BRIEF.md
# Operand-Timed Sequential Divider

This block divides a 32-bit dividend by a 16-bit divisor, either as unsigned numbers or as two's-complement numbers, and produces a 16-bit quotient and a 16-bit remainder. A single-cycle `start` pulse latches the operands and the mode. The block then works through a bit-serial restoring division. It raises `done` only when a microcycle timing model says the operation would finish. The delay therefore depends on the operand values and matches that model clock for clock.

The timing model counts microcycles. The clock count is twice the microcycle total. The value reported on `cycleCount` is that clock count minus 4, and `done` appears exactly that many clock edges after the edge that took `start`. The model's sources of variation are:
- an early exit on overflow;
- a penalty for each shift step, set by the shifted-out bit and by whether a subtraction happened;
- offsets that depend on the operand signs;
- a count of zero bits in the absolute quotient.

The flags and the count change only in the cycle where `done` is high. On overflow or a zero divisor, the quotient and remainder keep their previous values.

Top module: `cycDiv`

## Requirements
- R1: A zero divisor sets `divZero`=1, `overflow`=0 and `cycleCount`=0 and pulses `done` 1 clock after the start edge. The quotient and remainder stay unchanged.
- R2: In unsigned mode (`signedMode`=0), if `dividend[31:16]` >= `divisor`, the block sets `overflow`=1 with `cycleCount`=6 (5 microcycles) and leaves the quotient and remainder unchanged.
- R3: In unsigned mode without overflow, `quotient` = floor(dividend/divisor), `remainder` = dividend mod divisor, and `overflow`=0.
- R4: In unsigned mode without overflow, the microcycle total starts at 38 and runs 15 shift-left steps of the 32-bit dividend against divisor<<16. A step that shifts out a 1 subtracts and adds nothing. Any other step adds 2, and if the shifted value is >= divisor<<16 it subtracts and takes 1 back. `cycleCount` = 2*total-4.
- R5: In signed mode (`signedMode`=1), absolute overflow occurs when |dividend|>>16 >= |divisor|. It sets `overflow`=1 with `cycleCount` = 2*(8+n)-4, where n=1 for a negative dividend and 0 otherwise. The quotient and remainder stay unchanged.
- R6: In signed mode without absolute overflow, the total is 61+n. A non-negative divisor then adds -1 when the dividend is non-negative and +1 when it is negative. One more is added for each zero among bits 15..1 of the 16-bit absolute quotient. `cycleCount` = 2*total-4.
- R7: A signed result has its quotient truncated toward zero and a remainder that carries the sign of the dividend, both in two's complement.
- R8: If the signed quotient falls outside -32768..32767, the block sets `overflow`=1 only after the full R6 latency and leaves the quotient and remainder unchanged.
- R9: `done` is high for exactly one clock, `cycleCount` edges after the start edge (1 edge for a zero divisor). All result outputs stay constant in every cycle where `done` is low.
- R10: A `start` that arrives while an operation is in progress is ignored and does not alter that operation's results or timing.
- R11: After reset, `done`, `overflow` and `divZero` are 0, and `quotient`, `remainder` and `cycleCount` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| signedMode | input | 1 | 0 = unsigned, 1 = two's-complement |
| dividend | input | 32 | Dividend |
| divisor | input | 16 | Divisor |
| quotient | output | 16 | Last valid quotient |
| remainder | output | 16 | Last valid remainder |
| overflow | output | 1 | Result did not fit in 16 bits |
| divZero | output | 1 | Divisor was zero |
| done | output | 1 | One-clock completion strobe |
| cycleCount | output | CNT_W (8) | Modelled clock count minus 4 |

## Verification
The bench builds the block with its default 8-bit count width. That width covers the longest signed run of 152 reported clocks, so every latency produced by the model can be observed without wrap. Because the elapsed counter and the count output share this width, the bench can cover both ends of the range: the 1-clock zero-divisor exit and signed runs near the top of the range. Operands are chosen so that the timing-model penalties differ between cases, and the bench compares `done` and the held outputs against its own model on every clock.

// File: rtl/divPkg.sv
package divPkg;
  localparam int DD_W = 32;
  localparam int DV_W = 16;

  // microcycle constants of the timing model
  localparam int U_OVF_MC  = 5;
  localparam int U_BASE_MC = 38;
  localparam int S_OVF_MC  = 8;
  localparam int S_BASE_MC = 60;
  localparam int CLK_TRIM  = 4;

  typedef enum logic {ST_IDLE, ST_RUN} divState_t;

  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } ctrl_t;
endpackage

// File: rtl/divCtrl.sv
module divCtrl import divPkg::*; #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             ready,
  input  logic [CNT_W-1:0] fireAt,
  output ctrl_t            ctl,
  output logic             done
);
  divState_t state;
  logic [CNT_W-1:0] elapsed;
  logic hitTarget;

  assign hitTarget = ready && (elapsed == fireAt);

  always_comb begin
    ctl = '0;
    ctl.load   = (state == ST_IDLE) && start;
    ctl.step   = (state == ST_RUN);
    ctl.finish = (state == ST_RUN) && hitTarget;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      elapsed <= '0;
      done    <= 1'b0;
    end else begin
      done <= ctl.finish;
      if (ctl.load) begin
        state   <= ST_RUN;
        elapsed <= CNT_W'(1);
      end else if (ctl.finish) begin
        state <= ST_IDLE;
      end else if (state == ST_RUN) begin
        elapsed <= elapsed + 1'b1;
      end
    end
  end
endmodule

// File: rtl/divDatapath.sv
module divDatapath import divPkg::*; #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_t            ctl,
  input  logic             startSigned,
  input  logic [DD_W-1:0]  startDividend,
  input  logic [DV_W-1:0]  startDivisor,
  output logic             ready,
  output logic [CNT_W-1:0] fireAt,
  output logic [DV_W-1:0]  quotient,
  output logic [DV_W-1:0]  remainder,
  output logic             overflow,
  output logic             divZero,
  output logic [CNT_W-1:0] cycleCount
);
  localparam int STEPS   = DV_W;
  localparam int PEN_STEPS = DV_W - 1;
  localparam int STEP_W  = $clog2(STEPS + 1);
  localparam int PEN_W   = $clog2(2 * STEPS + 1);

  logic             modeS, ddNeg, dvNeg, zeroR, earlyR;
  logic [DD_W-1:0]  work;
  logic [DV_W-1:0]  magDv;
  logic [STEP_W-1:0] stepCnt;
  logic [PEN_W-1:0] penalty;

  // operand decode at load
  logic             ldDdNeg, ldDvNeg;
  logic [DD_W-1:0]  ldMagDd;
  logic [DV_W-1:0]  ldMagDv;
  always_comb begin
    ldDdNeg = startSigned & startDividend[DD_W-1];
    ldDvNeg = startSigned & startDivisor[DV_W-1];
    ldMagDd = ldDdNeg ? (~startDividend + 1'b1) : startDividend;
    ldMagDv = ldDvNeg ? (~startDivisor + 1'b1) : startDivisor;
  end

  // one restoring step
  logic             carry, ge, running;
  logic [DV_W:0]    shifted, diff;
  logic [DV_W-1:0]  newHi;
  logic [PEN_W-1:0] stepPen;
  always_comb begin
    carry   = work[DD_W-1];
    shifted = {work[DD_W-1:DV_W], work[DV_W-1]};
    diff    = shifted - {1'b0, magDv};
    ge      = shifted >= {1'b0, magDv};
    newHi   = ge ? diff[DV_W-1:0] : shifted[DV_W-1:0];
    stepPen = carry ? PEN_W'(0) : (ge ? PEN_W'(1) : PEN_W'(2));
    running = (stepCnt != STEP_W'(STEPS)) && !zeroR && !earlyR;
  end

  // result and timing evaluation
  logic [DV_W-1:0]  absQ, absR;
  logic             qNeg, sOvf;
  logic [CNT_W-1:0] zeroCnt, mc, clocks;
  always_comb begin
    absQ = work[DV_W-1:0];
    absR = work[DD_W-1:DV_W];
    qNeg = ddNeg ^ dvNeg;
    sOvf = modeS && (qNeg ? (absQ > {1'b1, {(DV_W-1){1'b0}}}) : absQ[DV_W-1]);
    zeroCnt = '0;
    for (int i = 1; i < DV_W; i++) begin
      if (!absQ[i]) zeroCnt = zeroCnt + 1'b1;
    end
    if (earlyR)
      mc = modeS ? CNT_W'(S_OVF_MC) + CNT_W'(ddNeg) : CNT_W'(U_OVF_MC);
    else if (modeS)
      mc = CNT_W'(S_BASE_MC) + CNT_W'(ddNeg) + zeroCnt
         + (dvNeg ? CNT_W'(1) : (ddNeg ? CNT_W'(2) : CNT_W'(0)));
    else
      mc = CNT_W'(U_BASE_MC) + CNT_W'(penalty);
    clocks = zeroR ? '0 : ({mc[CNT_W-2:0], 1'b0} - CNT_W'(CLK_TRIM));
    fireAt = zeroR ? CNT_W'(1) : clocks;
    ready  = zeroR || earlyR || (stepCnt == STEP_W'(STEPS));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeS <= 1'b0; ddNeg <= 1'b0; dvNeg <= 1'b0;
      zeroR <= 1'b0; earlyR <= 1'b0;
      work <= '0; magDv <= '0; stepCnt <= '0; penalty <= '0;
      quotient <= '0; remainder <= '0;
      overflow <= 1'b0; divZero <= 1'b0; cycleCount <= '0;
    end else begin
      if (ctl.load) begin
        modeS   <= startSigned;
        ddNeg   <= ldDdNeg;
        dvNeg   <= ldDvNeg;
        zeroR   <= (ldMagDv == '0);
        earlyR  <= (ldMagDv != '0) && (ldMagDd[DD_W-1:DV_W] >= ldMagDv);
        work    <= ldMagDd;
        magDv   <= ldMagDv;
        stepCnt <= '0;
        penalty <= '0;
      end else if (ctl.step && running) begin
        work    <= {newHi, work[DV_W-2:0], ge};
        stepCnt <= stepCnt + 1'b1;
        if (stepCnt < STEP_W'(PEN_STEPS)) penalty <= penalty + stepPen;
      end
      if (ctl.finish) begin
        cycleCount <= clocks;
        divZero    <= zeroR;
        overflow   <= !zeroR && (earlyR || sOvf);
        if (!zeroR && !earlyR && !sOvf) begin
          quotient  <= (modeS && qNeg) ? (~absQ + 1'b1) : absQ;
          remainder <= ddNeg ? (~absR + 1'b1) : absR;
        end
      end
    end
  end
endmodule

// File: rtl/cycDiv.sv
module cycDiv import divPkg::*; #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             signedMode,
  input  logic [31:0]      dividend,
  input  logic [15:0]      divisor,
  output logic [15:0]      quotient,
  output logic [15:0]      remainder,
  output logic             overflow,
  output logic             divZero,
  output logic             done,
  output logic [CNT_W-1:0] cycleCount
);
  ctrl_t            ctl;
  logic             ready;
  logic [CNT_W-1:0] fireAt;

  divCtrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .ready(ready),
    .fireAt(fireAt), .ctl(ctl), .done(done)
  );

  divDatapath #(.CNT_W(CNT_W)) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .startSigned(signedMode),
    .startDividend(dividend), .startDivisor(divisor),
    .ready(ready), .fireAt(fireAt),
    .quotient(quotient), .remainder(remainder),
    .overflow(overflow), .divZero(divZero), .cycleCount(cycleCount)
  );
endmodule

// File: rtl/divChecker.sv
module divChecker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             done,
  input logic             overflow,
  input logic             divZero,
  input logic [15:0]      quotient,
  input logic [15:0]      remainder,
  input logic [CNT_W-1:0] cycleCount
);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  hold_outputs_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(quotient) && $stable(remainder) && $stable(cycleCount)
               && $stable(overflow) && $stable(divZero)));

  // R1
  zero_div_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && divZero) |-> (cycleCount == '0 && !overflow));

  // R2
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && overflow) |-> ($stable(quotient) && $stable(remainder)));

  // R5
  ovf_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && overflow) |-> (cycleCount == CNT_W'(6) || cycleCount == CNT_W'(12)
                            || cycleCount == CNT_W'(14) || cycleCount >= CNT_W'(116)));

  // R6
  full_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !overflow && !divZero) |-> (cycleCount >= CNT_W'(72) && cycleCount <= CNT_W'(152)));
endmodule

bind cycDiv divChecker #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .done(done), .overflow(overflow), .divZero(divZero),
  .quotient(quotient), .remainder(remainder), .cycleCount(cycleCount)
);

// File: tb/tb_cycDiv.sv
`timescale 1ns/1ps
module tb_cycDiv;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        signedMode = 1'b0;
  logic [31:0] dividend = '0;
  logic [15:0] divisor = '0;
  logic [15:0] quotient, remainder;
  logic        overflow, divZero, done;
  logic [7:0]  cycleCount;

  int nChecks = 0;
  int nFails = 0;
  logic [15:0] expQ = '0;
  logic [15:0] expR = '0;

  always #2.5 clk = ~clk;

  cycDiv dut (
    .clk(clk), .rstN(rstN), .start(start), .signedMode(signedMode),
    .dividend(dividend), .divisor(divisor), .quotient(quotient),
    .remainder(remainder), .overflow(overflow), .divZero(divZero),
    .done(done), .cycleCount(cycleCount)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int refCount(input bit sm, input logic [31:0] dd, input logic [15:0] dv);
    longint d, hd, t, sdd, sdv, ad, av, aq;
    int mc;
    if (dv == 16'h0) return 0;
    if (!sm) begin
      d = longint'(dd);
      if ((d >> 16) >= longint'(dv)) return 6;
      mc = 38;
      hd = longint'(dv) << 16;
      for (int i = 0; i < 15; i++) begin
        t = d;
        d = (d << 1) & 64'hFFFF_FFFF;
        if ((t & 64'h8000_0000) != 0) d = (d - hd) & 64'hFFFF_FFFF;
        else begin
          mc += 2;
          if (d >= hd) begin d = d - hd; mc--; end
        end
      end
      return 2 * mc - 4;
    end
    sdd = longint'($signed(dd));
    sdv = longint'($signed(dv));
    mc = 6;
    if (sdd < 0) mc++;
    ad = (sdd < 0) ? -sdd : sdd;
    av = (sdv < 0) ? -sdv : sdv;
    if ((ad >> 16) >= av) return 2 * (mc + 2) - 4;
    aq = ad / av;
    mc += 55;
    if (sdv >= 0) mc += (sdd >= 0) ? -1 : 1;
    for (int i = 0; i < 15; i++) begin
      if ((aq & 'h8000) == 0) mc++;
      aq = (aq << 1) & 'hFFFF;
    end
    return 2 * mc - 4;
  endfunction

  task automatic runOp(input string tag, input bit sm, input logic [31:0] dd,
                       input logic [15:0] dv, input bit poke);
    int cnt, lat;
    bit eOvf, eDz;
    longint q, r, sdd, sdv;
    cnt = refCount(sm, dd, dv);
    lat = (cnt == 0) ? 1 : cnt;
    eDz = (dv == 16'h0);
    eOvf = 1'b0;
    q = 0; r = 0;
    if (!eDz) begin
      if (!sm) begin
        if (dd[31:16] >= dv) eOvf = 1'b1;
        else begin q = longint'(dd) / longint'(dv); r = longint'(dd) % longint'(dv); end
      end else begin
        sdd = longint'($signed(dd));
        sdv = longint'($signed(dv));
        if (cnt <= 14) eOvf = 1'b1;
        else begin
          q = sdd / sdv;
          r = sdd % sdv;
          if (q > 32767 || q < -32768) eOvf = 1'b1;
        end
      end
    end
    @(negedge clk);
    start = 1'b1; signedMode = sm; dividend = dd; divisor = dv;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R9 no early done"}, done, 0);
    for (int k = 1; k <= lat; k++) begin
      if (poke && k == 3) begin
        start = 1'b1; signedMode = ~sm; dividend = 32'h0000_0001; divisor = 16'h0000;
      end
      @(negedge clk);
      if (poke && k == 3) start = 1'b0;
      chk({tag, " R9 done timing"}, done, (k == lat) ? 1 : 0);
      if (k < lat) begin
        chk({tag, " R9 hold quotient"}, quotient, expQ);
        chk({tag, " R9 hold remainder"}, remainder, expR);
      end
    end
    if (!eDz && !eOvf) begin
      expQ = q[15:0];
      expR = r[15:0];
    end
    chk({tag, " R1 divZero"}, divZero, eDz);
    chk({tag, " R2 R5 R8 overflow"}, overflow, eOvf);
    chk({tag, " R4 R6 cycleCount"}, cycleCount, cnt);
    chk({tag, " R3 R7 quotient"}, quotient, expQ);
    chk({tag, " R3 R7 remainder"}, remainder, expR);
    @(negedge clk);
    chk({tag, " R9 single pulse"}, done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 done", done, 0);
    chk("R11 overflow", overflow, 0);
    chk("R11 divZero", divZero, 0);
    chk("R11 quotient", quotient, 0);
    chk("R11 remainder", remainder, 0);
    chk("R11 cycleCount", cycleCount, 0);

    runOp("R3 basic", 1'b0, 32'h0001_2345, 16'h0100, 1'b0);
    runOp("R4 q max", 1'b0, 32'h0000_FFFF, 16'h0001, 1'b0);
    runOp("R4 zero", 1'b0, 32'h0000_0000, 16'h0001, 1'b0);
    runOp("R4 carries", 1'b0, 32'hFFFE_FFFF, 16'hFFFF, 1'b0);
    runOp("R3 mixed", 1'b0, 32'h7654_3210, 16'h9ABC, 1'b0);
    runOp("R2 ovf", 1'b0, 32'h0005_0000, 16'h0005, 1'b0);
    runOp("R1 zero u", 1'b0, 32'h1234_5678, 16'h0000, 1'b0);
    runOp("R7 pp", 1'b1, 32'h0000_1000, 16'h0007, 1'b0);
    runOp("R7 np", 1'b1, 32'hFFFF_F000, 16'h0007, 1'b0);
    runOp("R7 pn", 1'b1, 32'h0000_1000, 16'hFFF9, 1'b0);
    runOp("R7 nn", 1'b1, 32'hFFFF_F000, 16'hFFF9, 1'b0);
    runOp("R6 minDv", 1'b1, 32'h1234_5678, 16'h8000, 1'b0);
    runOp("R6 minQ", 1'b1, 32'hFFFF_8000, 16'h0001, 1'b0);
    runOp("R6 zeroQ", 1'b1, 32'h0000_0003, 16'h7FFF, 1'b0);
    runOp("R5 abs ovf p", 1'b1, 32'h0001_0000, 16'h0001, 1'b0);
    runOp("R5 abs ovf n", 1'b1, 32'hFFF0_0000, 16'h0010, 1'b0);
    runOp("R8 pos ovf", 1'b1, 32'h0000_8000, 16'h0001, 1'b0);
    runOp("R8 neg ovf", 1'b1, 32'h0000_8001, 16'hFFFF, 1'b0);
    runOp("R1 zero s", 1'b1, 32'h8000_0000, 16'h0000, 1'b0);
    runOp("R10 busy start", 1'b0, 32'h0012_3456, 16'h0789, 1'b1);
    runOp("R10 busy start s", 1'b1, 32'hFF00_1234, 16'h0456, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule